// File: doc/BRIEF.md
# Oscillator Halt Pin Safing Controller

This block watches the main oscillator with a separate check clock that never stops. The oscillator input is synchronised into the check-clock domain and its transitions are detected there. If no transition arrives for a set number of check-clock cycles, the block raises a halt flag. The flag stays set until the next reset. While the flag is set, the block takes the output enables of a group of six high-current pins away from the pin-function multiplexer, so those pins float whatever function they have been given.

The same tri-stating applies while the device sits in software standby. Halt detection is masked during standby, because the oscillator may stop legitimately there. The pins go back to multiplexer control as soon as standby ends. A software safing enable gates all forcing. When a debugger is attached, three of the six pins keep their multiplexer enables so that the debug link still works. Output data always passes straight through, and only the enables are overridden.

Top module: `osc_halt_safing`

## Requirements
- R1: Once armed, `halt_det` rises at the check-clock edge that completes TIMEOUT (default 16) consecutive check-clock cycles without a detected oscillator edge. A transition on `osc_in` is detected three check-clock edges after it is sampled: two synchroniser flops plus one history flop. If the oscillator half-period is exactly TIMEOUT check cycles, no halt is raised. If it is TIMEOUT+1 cycles, a halt is raised.
- R2: While `halt_det`=1, `safe_en`=1 and `dbg_attached`=0, every bit of `pin_oe` is 0, whatever `mux_oe` holds.
- R3: While `standby`=1, `safe_en`=1 and `dbg_attached`=0, every bit of `pin_oe` is 0, whatever `mux_oe` holds.
- R4: When standby is left and no halt is latched, `pin_oe` equals `mux_oe` in the same cycle. With the oscillator running, no halt follows the exit, because the quiet counter restarts from zero.
- R5: With `dbg_attached`=1 and forcing active, bits 2:0 of `pin_oe` follow `mux_oe` and bits 5:3 are 0.
- R6: Once set, `halt_det` stays 1 and the forcing stays in place until `rst_n` is asserted, even after the oscillator toggles again.
- R7: With `safe_en`=0, `pin_oe` equals `mux_oe` at all times. `halt_det` still reports a halt.
- R8: No halt is latched while `standby`=1. This includes a cycle in which the quiet count would otherwise expire.
- R9: After reset, no halt is detected until at least one oscillator edge has been seen.
- R10: `pin_dout` always equals `mux_dout`.
- R11: While `rst_n` is low, `halt_det` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_clk | input | 1 | Independent, always-running check clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Main oscillator signal under watch |
| standby | input | 1 | Device is in software standby |
| dbg_attached | input | 1 | Debugger attached; exempts pins 2:0 |
| safe_en | input | 1 | Software enable for all forcing |
| mux_dout | input | NPINS | Per-pin output data from the pin multiplexer |
| mux_oe | input | NPINS | Per-pin output enables from the pin multiplexer |
| pin_dout | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Final output enables to the pads |
| halt_det | output | 1 | Sticky oscillator-halt flag |

## Verification
Standby entry and the expiry of the quiet count can land on the same check-clock edge. The bench provokes this by stopping the oscillator and tracking its own quiet count. It raises `standby` on the falling edge just before the edge on which the count would expire. It then judges that `halt_det` stays low and that the pins are tri-stated by standby alone. They must return to multiplexer control once standby drops and the oscillator restarts.

// File: rtl/osc_halt_safing.sv
module osc_halt_safing #(
  parameter int NPINS = 6,
  parameter int TIMEOUT = 16,
  parameter logic [NPINS-1:0] DBG_KEEP = 6'b000111
) (
  input  logic             chk_clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             standby,
  input  logic             dbg_attached,
  input  logic             safe_en,
  input  logic [NPINS-1:0] mux_dout,
  input  logic [NPINS-1:0] mux_oe,
  output logic [NPINS-1:0] pin_dout,
  output logic [NPINS-1:0] pin_oe,
  output logic             halt_det
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(TIMEOUT);

  logic [2:0]       osc_sh;
  logic             armed;
  logic             halt_q;
  logic [CNT_W-1:0] quiet;

  wire osc_edge = osc_sh[1] ^ osc_sh[2];
  wire expire   = armed && !standby && !osc_edge && (quiet == LAST);

  always_ff @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_sh <= '0;
      armed  <= 1'b0;
      halt_q <= 1'b0;
      quiet  <= '0;
    end else begin
      osc_sh <= {osc_sh[1:0], osc_in};
      armed  <= armed | osc_edge;
      halt_q <= halt_q | expire;
      if (osc_edge || standby || !armed)
        quiet <= '0;
      else if (quiet != SAT)
        quiet <= quiet + 1'b1;
    end
  end

  wire             force_any = safe_en && (halt_q || standby);
  wire [NPINS-1:0] keep_mask = dbg_attached ? DBG_KEEP : '0;
  wire [NPINS-1:0] force_vec = {NPINS{force_any}} & ~keep_mask;

  assign pin_oe   = mux_oe & ~force_vec;
  assign pin_dout = mux_dout;
  assign halt_det = halt_q;
endmodule

module osc_halt_safing_chk #(
  parameter int NPINS = 6,
  parameter logic [NPINS-1:0] DBG_KEEP = 6'b000111
) (
  input logic             chk_clk,
  input logic             rst_n,
  input logic             standby,
  input logic             dbg_attached,
  input logic             safe_en,
  input logic [NPINS-1:0] mux_oe,
  input logic [NPINS-1:0] pin_oe,
  input logic             halt_det
);
  AST_HALT_FORCE: assert property (@(posedge chk_clk) disable iff (!rst_n)
    (halt_det && safe_en && !dbg_attached) |-> (pin_oe == '0)); // R2
  AST_STBY_FORCE: assert property (@(posedge chk_clk) disable iff (!rst_n)
    (standby && safe_en && !dbg_attached) |-> (pin_oe == '0)); // R3
  AST_DBG_KEEP: assert property (@(posedge chk_clk) disable iff (!rst_n)
    (dbg_attached && safe_en) |-> ((pin_oe & DBG_KEEP) == (mux_oe & DBG_KEEP))); // R5
  AST_HALT_STICKY: assert property (@(posedge chk_clk) disable iff (!rst_n)
    halt_det |=> halt_det); // R6
  AST_SAFE_OFF: assert property (@(posedge chk_clk) disable iff (!rst_n)
    !safe_en |-> (pin_oe == mux_oe)); // R7
  AST_NO_HALT_STBY: assert property (@(posedge chk_clk) disable iff (!rst_n)
    $rose(halt_det) |-> !$past(standby)); // R8
  AST_RESET_CLEAR: assert property (@(posedge chk_clk)
    !rst_n |-> !halt_det); // R11
endmodule

bind osc_halt_safing osc_halt_safing_chk #(.NPINS(NPINS), .DBG_KEEP(DBG_KEEP)) u_chk (.*);

// File: tb/tb_osc_halt_safing.sv
`timescale 1ns/1ps
module tb_osc_halt_safing;
  localparam int NP = 6;
  localparam int TO = 16;
  localparam logic [NP-1:0] KEEP = 6'b000111;

  logic chk_clk = 0, rst_n = 0, osc_in = 0, standby = 0, dbg_attached = 0, safe_en = 1;
  logic [NP-1:0] mux_dout = '0, mux_oe = '0;
  logic [NP-1:0] pin_dout, pin_oe;
  logic halt_det;

  osc_halt_safing #(.NPINS(NP), .TIMEOUT(TO), .DBG_KEEP(KEEP)) dut (
    .chk_clk(chk_clk), .rst_n(rst_n), .osc_in(osc_in), .standby(standby),
    .dbg_attached(dbg_attached), .safe_en(safe_en), .mux_dout(mux_dout),
    .mux_oe(mux_oe), .pin_dout(pin_dout), .pin_oe(pin_oe), .halt_det(halt_det));

  always #10 chk_clk = ~chk_clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  bit q[$];
  bit m_armed, m_halt;
  int m_quiet;

  always @(posedge chk_clk or negedge rst_n) begin
    if (!rst_n) begin
      q = {1'b0, 1'b0, 1'b0};
      m_armed = 0; m_halt = 0; m_quiet = 0;
    end else begin
      bit e;
      e = (q[0] != q[1]);
      if (!m_halt && m_armed && !standby && !e && m_quiet == TO - 1) m_halt = 1;
      if (e || standby || !m_armed) m_quiet = 0;
      else if (m_quiet < TO) m_quiet++;
      if (e) m_armed = 1;
      q.push_back(osc_in);
      void'(q.pop_front());
    end
  end

  always @(posedge chk_clk) begin
    #5;
    if (rst_n && !done) begin
      logic [NP-1:0] frc, exp_oe;
      string ht, ot;
      frc = (safe_en && (m_halt || standby)) ? (dbg_attached ? ~KEEP : '1) : '0;
      exp_oe = mux_oe & ~frc;
      ht = standby ? "R8" : (!m_armed ? "R9" : (m_halt ? "R6" : "R1"));
      ot = !safe_en ? "R7" : (dbg_attached ? "R5" : (standby ? "R3" : (m_halt ? "R2" : "R4")));
      check(ht, 32'(halt_det), 32'(m_halt));
      check(ot, 32'(pin_oe), 32'(exp_oe));
      check("R10", 32'(pin_dout), 32'(mux_dout));
    end
  end

  // stimulus generators
  bit osc_run = 0;
  int osc_half = 2;
  initial begin
    int ph = 0;
    forever begin
      @(negedge chk_clk);
      if (osc_run) begin
        ph++;
        if (ph >= osc_half) begin osc_in = ~osc_in; ph = 0; end
      end
    end
  end

  initial forever begin
    @(negedge chk_clk);
    mux_oe = NP'($urandom);
    mux_dout = NP'($urandom);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge chk_clk);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(2);
    #1 check("R11", 32'(halt_det), 0);
    rst_n = 1;
    cyc(40);
    #1 check("R9", 32'(halt_det), 0);

    osc_run = 1; cyc(30);
    osc_run = 0;
    forever begin @(negedge chk_clk); if (m_quiet == TO - 1) break; end
    standby = 1;
    cyc(5);
    #1 check("R8", 32'(halt_det), 0);
    #1 check("R3", 32'(pin_oe & ~mux_oe), 0);
    cyc(40);
    #1 check("R8", 32'(halt_det), 0);
    dbg_attached = 1;
    cyc(1);
    #1 check("R5", 32'(pin_oe & KEEP), 32'(mux_oe & KEEP));
    #1 check("R5", 32'(pin_oe & ~KEEP), 0);
    dbg_attached = 0; safe_en = 0;
    cyc(1);
    #1 check("R7", 32'(pin_oe), 32'(mux_oe));
    safe_en = 1;
    osc_run = 1; standby = 0;
    cyc(1);
    #1 check("R4", 32'(pin_oe), 32'(mux_oe));
    cyc(40);
    #1 check("R4", 32'(halt_det), 0);

    osc_half = TO; cyc(100);
    #1 check("R1", 32'(halt_det), 0);
    osc_half = TO + 1; cyc(60);
    #1 check("R1", 32'(halt_det), 1);
    #1 check("R2", 32'(pin_oe), 0);
    dbg_attached = 1; cyc(3);
    #1 check("R5", 32'(pin_oe & KEEP), 32'(mux_oe & KEEP));
    dbg_attached = 0; safe_en = 0; cyc(3);
    #1 check("R7", 32'(halt_det), 1);
    safe_en = 1;
    osc_half = 2; cyc(40);
    #1 check("R6", 32'(halt_det), 1);
    #1 check("R6", 32'(pin_oe), 0);

    osc_run = 0; osc_half = 2; cyc(1);
    rst_n = 0; cyc(2);
    #1 check("R11", 32'(halt_det), 0);
    rst_n = 1; osc_run = 1; cyc(30);
    osc_run = 0; cyc(30);
    #1 check("R1", 32'(halt_det), 1);
    cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule